// File: doc/BRIEF.md
# Table-Driven Predecoded Row Select

This block turns a binary row address into a one-hot row-select vector for a memory array of 3 to 4096 rows. It does not use one flat decoder. The address is cut into short fields of 2, 3 or 4 bits. Each field feeds a small predecoder that raises one of 4, 8 or 16 lines. Every row output is then a single AND term, taking one line from each field's group. The result is combinational: the row select follows the address and enable with no clock.

The address width is `$clog2(ROWS)`. For each width from 2 to 12, a fixed table sets how many predecoders of each size are used. Any width outside that range stops elaboration. The flat bus of predecode lines is brought out next to the row selects, so that the field split and line order can be observed from outside.

Top module: `rowdec_top`

## Requirements
- R1: With `en` high and `addr` below `ROWS`, row output number `addr` is high and every other row output is low.
- R2: With `en` low, every row output and every predecode line is low, whatever the address.
- R3: When `ROWS` is not a power of two and `en` is high, an address at or above `ROWS` raises no row output. The predecode lines still follow that address.
- R4: The predecode groups sit in the flat bus with 2-bit groups first, then 3-bit groups, then 4-bit groups. The groups take address bits from bit 0 upward, in that same order. A group's lines start at the sum of the line counts of the groups before it. With `en` high, exactly one line of each group is high: the one at the group's base index plus the value of its address field.
- R5: The group mix, written (2-bit, 3-bit, 4-bit) per address width, is: 2:(1,0,0), 3:(0,1,0), 4:(2,0,0), 5:(1,1,0), 6:(3,0,0), 7:(2,1,0), 8:(1,2,0), 9:(0,3,0), 10:(0,2,1), 11:(0,1,2), 12:(0,0,3). The predecode bus is 4·a + 8·b + 16·c lines wide.
- R6: At address widths 2 and 3, with `ROWS` a power of two, one predecoder forms the whole decoder and the row vector equals the predecode bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr | input | $clog2(ROWS) | Binary row address |
| en | input | 1 | Enable; low forces all lines and rows low |
| row_sel | output | ROWS | One-hot row select |
| predec | output | 4a+8b+16c | Flat bus of predecode lines, grouped by field |

## Verification
If a predecoder has its literal polarity or field offset wrong, the fault shows at once. For the affected addresses the predecode bus has the wrong line high, and the row vector holds a different row or two rows. If a row's AND term is wired to the wrong line, the row is missing or duplicated only for the addresses whose field values meet that line. For that reason every address is swept at every width. Because the path has no registers, each fault shows up in the same cycle in which the address is applied.

// File: rtl/rowdec_pkg.sv
// Package: shared constants and elaboration-time functions for the
// predecoded row select. All functions are pure and used only to
// size and place the predecoder groups; nothing here is clocked.
package rowdec_pkg;

    localparam int MIN_AW     = 2;
    localparam int MAX_AW     = 12;
    localparam int MAX_GROUPS = 3;

    // Number of predecoders of field width fw (2, 3 or 4) at address width aw.
    function automatic int mix_count(input int aw, input int fw);
        int c2, c3, c4;
        c2 = 0; c3 = 0; c4 = 0;
        case (aw)
            2:  c2 = 1;
            3:  c3 = 1;
            4:  c2 = 2;
            5:  begin c2 = 1; c3 = 1; end
            6:  c2 = 3;
            7:  begin c2 = 2; c3 = 1; end
            8:  begin c2 = 1; c3 = 2; end
            9:  c3 = 3;
            10: begin c3 = 2; c4 = 1; end
            11: begin c3 = 1; c4 = 2; end
            12: c4 = 3;
            default: ;
        endcase
        case (fw)
            2:       return c2;
            3:       return c3;
            4:       return c4;
            default: return 0;
        endcase
    endfunction

    // Total predecoder groups at address width aw.
    function automatic int group_count(input int aw);
        return mix_count(aw, 2) + mix_count(aw, 3) + mix_count(aw, 4);
    endfunction

    // Field width of group g: narrow groups first.
    function automatic int grp_width(input int aw, input int g);
        if (g < mix_count(aw, 2))                    return 2;
        if (g < mix_count(aw, 2) + mix_count(aw, 3)) return 3;
        return 4;
    endfunction

    // Lowest address bit consumed by group g.
    function automatic int grp_bit_lo(input int aw, input int g);
        int s;
        s = 0;
        for (int h = 0; h < g; h++) s += grp_width(aw, h);
        return s;
    endfunction

    // First predecode line index owned by group g.
    function automatic int grp_line_lo(input int aw, input int g);
        int s;
        s = 0;
        for (int h = 0; h < g; h++) s += (1 << grp_width(aw, h));
        return s;
    endfunction

    // Width of the flat predecode bus.
    function automatic int total_lines(input int aw);
        return grp_line_lo(aw, group_count(aw));
    endfunction

endpackage

// File: rtl/rowdec_predec.sv
// Module: one W-to-2^W predecoder. Each output is an AND of W address
// literals and the enable, so the outputs are one-hot while en is high
// and all low while en is low. Assumes 2 <= W <= 4.
module rowdec_predec #(
    parameter  int W  = 2,
    localparam int NL = 1 << W
) (
    input  logic [W-1:0]  field,
    input  logic          en,
    output logic [NL-1:0] lines
);

    for (genvar i = 0; i < NL; i++) begin : g_line
        logic [W-1:0] lit;
        // Pick true or complemented address bit per code position.
        for (genvar b = 0; b < W; b++) begin : g_lit
            if (((i >> b) & 1) == 1) begin : g_true
                assign lit[b] = field[b];
            end else begin : g_comp
                assign lit[b] = ~field[b];
            end
        end
        // Final AND term for this predecode line.
        assign lines[i] = en & (&lit);
    end

endmodule

// File: rtl/rowdec_and_plane.sv
// Module: final AND plane. Row r takes, from each group, the line
// whose index matches the field of r that the group decodes, and
// ANDs them. Group 0 holds the least significant field. Only rows below
// ROWS are built; lines that no built row uses are left unconnected.
module rowdec_and_plane
    import rowdec_pkg::*;
#(
    parameter  int ROWS = 256,
    localparam int AW   = $clog2(ROWS),
    localparam int NG   = group_count(AW),
    localparam int NL   = total_lines(AW)
) (
    input  logic [NL-1:0]   predec,
    output logic [ROWS-1:0] row_sel
);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [NG-1:0] terms;
        // Gather one line per group for this row.
        for (genvar g = 0; g < NG; g++) begin : g_term
            localparam int FW  = grp_width(AW, g);
            localparam int BLO = grp_bit_lo(AW, g);
            localparam int LLO = grp_line_lo(AW, g);
            localparam int FV  = (r >> BLO) & ((1 << FW) - 1);
            assign terms[g] = predec[LLO + FV];
        end
        // Row fires only when every group agrees.
        assign row_sel[r] = &terms;
    end

    // Lines beyond the last built row are deliberately unused.
    logic unused_lines;
    assign unused_lines = ^predec;

endmodule

// File: rtl/rowdec_top.sv
// Module: predecoded one-hot row select. Splits the address into the
// fields set by the width table, predecodes each field and
// combines one line per group in the AND plane. Purely combinational.
// Assumes 3 <= ROWS <= 4096; other address widths fail elaboration.
module rowdec_top
    import rowdec_pkg::*;
#(
    parameter  int ROWS = 256,
    localparam int AW   = $clog2(ROWS),
    localparam int NG   = group_count(AW),
    localparam int NL   = total_lines(AW)
) (
    input  logic [AW-1:0]   addr,
    input  logic            en,
    output logic [ROWS-1:0] row_sel,
    output logic [NL-1:0]   predec
);

    if (AW < MIN_AW || AW > MAX_AW) begin : g_bad_width
        $error("rowdec_top: address width %0d outside %0d..%0d", AW, MIN_AW, MAX_AW);
    end

    // One predecoder per field, placed by type order.
    for (genvar g = 0; g < NG; g++) begin : g_grp
        localparam int FW  = grp_width(AW, g);
        localparam int BLO = grp_bit_lo(AW, g);
        localparam int LLO = grp_line_lo(AW, g);
        rowdec_predec #(.W(FW)) u_predec (
            .field (addr[BLO +: FW]),
            .en    (en),
            .lines (predec[LLO +: (1 << FW)])
        );
    end

    rowdec_and_plane #(.ROWS(ROWS)) u_plane (
        .predec  (predec),
        .row_sel (row_sel)
    );

endmodule

// File: rtl/rowdec_chk.sv
// Module: checker bound to rowdec_top. Uses immediate assertions on
// the settled combinational outputs; no clock is needed.
module rowdec_chk
    import rowdec_pkg::*;
#(
    parameter  int ROWS = 256,
    localparam int AW   = $clog2(ROWS),
    localparam int NG   = group_count(AW),
    localparam int NL   = total_lines(AW)
) (
    input logic [AW-1:0]   addr,
    input logic            en,
    input logic [ROWS-1:0] row_sel,
    input logic [NL-1:0]   predec
);

    logic in_range;
    if (ROWS == (1 << AW)) begin : g_full
        assign in_range = 1'b1;
    end else begin : g_part
        assign in_range = (32'(addr) < ROWS);
    end

    // Row-level checks.
    always_comb begin
        if (en && in_range) begin
            AST_ONE_ROW: assert ($countones(row_sel) == 1) else $error("row select not one-hot"); // R1
            AST_ADDR_ROW: assert (row_sel[addr]) else $error("addressed row low"); // R1
        end
        if (!en) begin
            AST_IDLE_ROWS: assert (row_sel == '0) else $error("row high while disabled"); // R2
            AST_IDLE_LINES: assert (predec == '0) else $error("line high while disabled"); // R2
        end
        if (en && !in_range) begin
            AST_OOR_QUIET: assert (row_sel == '0) else $error("row high for out-of-range address"); // R3
        end
    end

    // Group-level checks.
    for (genvar g = 0; g < NG; g++) begin : g_grp
        localparam int FW  = grp_width(AW, g);
        localparam int BLO = grp_bit_lo(AW, g);
        localparam int LLO = grp_line_lo(AW, g);
        always_comb begin
            if (en) begin
                AST_GRP_ONEHOT: assert ($countones(predec[LLO +: (1 << FW)]) == 1) else $error("group not one-hot"); // R4
                AST_GRP_FIELD: assert (predec[LLO + 32'(addr[BLO +: FW])]) else $error("group line mismatch"); // R4
            end
        end
    end

endmodule

bind rowdec_top rowdec_chk #(.ROWS(ROWS)) u_chk (
    .addr    (addr),
    .en      (en),
    .row_sel (row_sel),
    .predec  (predec)
);

// File: tb/rowdec_top_bench.sv
// Bench: directed vector table on a 4096-row instance, then full
// address sweeps on instances across the width table.
module rowdec_top_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int n_checks = 0;
    int n_fails  = 0;
    int n_done   = 0;
    bit finished = 1'b0;

    // Independent copy of the mix table from the requirements (R5).
    function automatic int tb_count(input int aw, input int k);
        int t[3];
        case (aw)
            2: t = '{1,0,0};  3: t = '{0,1,0};  4: t = '{2,0,0};
            5: t = '{1,1,0};  6: t = '{3,0,0};  7: t = '{2,1,0};
            8: t = '{1,2,0};  9: t = '{0,3,0};  10: t = '{0,2,1};
            11: t = '{0,1,2}; 12: t = '{0,0,3};
            default: t = '{0,0,0};
        endcase
        return t[k];
    endfunction

    function automatic int tb_lines(input int aw);
        return 4 * tb_count(aw, 0) + 8 * tb_count(aw, 1) + 16 * tb_count(aw, 2);
    endfunction

    // Main instance: 4096 rows, three 4-bit groups.
    localparam int MROWS = 4096;
    localparam int MNL   = 48;
    logic [11:0]      m_addr;
    logic             m_en;
    logic [MROWS-1:0] m_row;
    logic [MNL-1:0]   m_pre;

    rowdec_top #(.ROWS(MROWS)) u_rowdec_top (
        .addr (m_addr), .en (m_en), .row_sel (m_row), .predec (m_pre)
    );

    typedef struct packed {
        logic [11:0] a;
        logic        e;
        logic [5:0]  l0;
        logic [5:0]  l1;
        logic [5:0]  l2;
    } vec_t;

    // Hand-computed lines: field k of a 12-bit address lands at 16k + field.
    localparam int NVEC = 7;
    localparam vec_t VEC [NVEC] = '{
        '{12'h000, 1'b1, 6'd0,  6'd16, 6'd32},
        '{12'hFFF, 1'b1, 6'd15, 6'd31, 6'd47},
        '{12'h5A3, 1'b1, 6'd3,  6'd26, 6'd37},
        '{12'h00F, 1'b1, 6'd15, 6'd16, 6'd32},
        '{12'h010, 1'b1, 6'd0,  6'd17, 6'd32},
        '{12'h800, 1'b1, 6'd0,  6'd16, 6'd40},
        '{12'hABC, 1'b0, 6'd0,  6'd0,  6'd0}
    };

    // Sweep instances covering every row of the width table.
    localparam int NCFG = 11;
    localparam int CFG_ROWS [NCFG] = '{4, 8, 16, 20, 64, 128, 256, 512, 1024, 2048, 4096};

    for (genvar ci = 0; ci < NCFG; ci++) begin : g_cfg
        localparam int ROWS = CFG_ROWS[ci];
        localparam int AW   = $clog2(ROWS);
        localparam int NL   = tb_lines(AW);
        logic [AW-1:0]   addr;
        logic            en;
        logic [ROWS-1:0] row_sel;
        logic [NL-1:0]   predec;

        rowdec_top #(.ROWS(ROWS)) u_rowdec_top (
            .addr (addr), .en (en), .row_sel (row_sel), .predec (predec)
        );

        initial begin
            logic [ROWS-1:0] er;
            logic [NL-1:0]   ep;
            int bpos, lpos;
            addr = '0;
            en   = 1'b0;
            wait (rst_n === 1'b1);
            for (int a = 0; a < (1 << AW); a++) begin
                for (int e = 0; e < 2; e++) begin
                    @(negedge clk);
                    addr = AW'(a);
                    en   = e[0];
                    @(posedge clk);
                    #2;
                    er = '0;
                    if (e == 1 && a < ROWS) er[a] = 1'b1;
                    ep = '0;
                    bpos = 0;
                    lpos = 0;
                    for (int k = 0; k < 3; k++) begin
                        for (int j = 0; j < tb_count(AW, k); j++) begin
                            if (e == 1) ep[lpos + ((a >> bpos) & ((1 << (k + 2)) - 1))] = 1'b1;
                            bpos += k + 2;
                            lpos += 1 << (k + 2);
                        end
                    end
                    n_checks++;
                    if (row_sel !== er) begin
                        n_fails++;
                        $display("FAIL %s rows=%0d addr=%0d en=%0d row_sel actual=%h expected=%h",
                                 (e == 0) ? "R2" : ((a < ROWS) ? "R1" : "R3"),
                                 ROWS, a, e, row_sel, er);
                    end
                    n_checks++;
                    if (predec !== ep) begin
                        n_fails++;
                        $display("FAIL %s rows=%0d addr=%0d en=%0d predec actual=%h expected=%h",
                                 (e == 0) ? "R2" : "R4/R5", ROWS, a, e, predec, ep);
                    end
                    if (AW < 4 && ROWS == (1 << AW)) begin
                        n_checks++;
                        if (32'(row_sel) !== 32'(predec)) begin
                            n_fails++;
                            $display("FAIL R6 rows=%0d addr=%0d row_sel actual=%h expected=%h",
                                     ROWS, a, row_sel, predec);
                        end
                    end
                end
            end
            n_done++;
        end
    end

    task automatic check_main(input string tag, input logic [MROWS-1:0] er,
                              input logic [MNL-1:0] ep);
        n_checks++;
        if (m_row !== er) begin
            n_fails++;
            $display("FAIL %s addr=%h row_sel actual=%h expected=%h", tag, m_addr, m_row, er);
        end
        n_checks++;
        if (m_pre !== ep) begin
            n_fails++;
            $display("FAIL %s addr=%h predec actual=%h expected=%h", tag, m_addr, m_pre, ep);
        end
    endtask

    initial begin
        logic [MROWS-1:0] er;
        logic [MNL-1:0]   ep;
        m_addr = 12'h3C5;
        m_en   = 1'b0;
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        // Reset state: disabled, nothing selected (R2).
        check_main("R2", '0, '0);

        // Vector table (R1, R4).
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            m_addr = VEC[v].a;
            m_en   = VEC[v].e;
            @(posedge clk);
            #2;
            er = '0;
            ep = '0;
            if (VEC[v].e) begin
                er[VEC[v].a] = 1'b1;
                ep[VEC[v].l0] = 1'b1;
                ep[VEC[v].l1] = 1'b1;
                ep[VEC[v].l2] = 1'b1;
            end
            check_main(VEC[v].e ? "R1/R4" : "R2", er, ep);
        end

        // Corner: en drops while address holds at top row (R2), then returns (R1).
        @(negedge clk);
        m_addr = 12'hFFF;
        m_en   = 1'b1;
        @(negedge clk);
        m_en = 1'b0;
        @(posedge clk);
        #2;
        check_main("R2", '0, '0);
        @(negedge clk);
        m_en = 1'b1;
        @(posedge clk);
        #2;
        er = '0;
        er[4095] = 1'b1;
        ep = '0;
        ep[15] = 1'b1; ep[31] = 1'b1; ep[47] = 1'b1;
        check_main("R1", er, ep);

        wait (n_done == NCFG);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run incomplete actual=%0d sweeps expected=%0d", n_done, NCFG);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule